// File: doc/BRIEF.md
# Gap-Delimited Serial Message Receiver

This block receives asynchronous serial characters on a single line, rebuilds each 8-bit character and hands it to an external receive FIFO through a one-cycle write strobe. A character starts with a low start bit. Its data bits arrive least significant first, and one or two high stop bits close it. Consecutive characters form one message. The message ends when the line has stayed idle for a programmable number of bit times.

When a message ends, the number of characters accepted into the FIFO during that message is latched into a 16-bit count and a sticky done flag is raised. The block also reports FIFO overflow and framing errors through sticky flags, and derives an almost-full flag from the FIFO's word count. Each sticky flag is cleared by pulsing a one on its bit of a clear vector. Bit timing uses a 16x oversampling tick derived from a clock-cycle divisor.

Top module: `uart_msg_rx`

## Requirements
- R1: A character is a low start bit followed by 8 data bits, least significant first, each sampled near its middle. A good character is written to `fifo_wr_data` with `fifo_wr_en` high for exactly one cycle.
- R2: A start bit is confirmed only if the line is still low half a bit time after the falling edge is seen. A low pulse shorter than half a bit produces no write.
- R3: When `two_stop` is 0, one high stop bit closes a character. When `two_stop` is 1, two stop bits are sampled and both must be high.
- R4: If any expected stop bit is sampled low, `rx_frame_err` is set and stays set. The character is neither written nor counted, and the receiver waits for the line to return high before it looks for a new start bit.
- R5: If `fifo_full` is high when a character completes, no write occurs, `rx_overflow` is set and stays set, and the character is not counted.
- R6: The sticky flags are cleared by a one on `clr_flags`: bit 0 clears `rx_done`, bit 1 clears `rx_overflow`, bit 2 clears `rx_frame_err`.
- R7: Once the line has been idle for `idle_bits` bit times after the last stop-bit sample, and at least one character was counted, `msg_count` takes that count, `rx_done` is set, and counting restarts from zero.
- R8: `msg_count` is 0 after reset and changes only at an end of message. An idle gap with no counted character changes neither `msg_count` nor `rx_done`.
- R9: `rx_almost_full` is high exactly when `fifo_count` is greater than or equal to `afull_level`.
- R10: While `rx_enable` is low, no start bit is detected and no character is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_enable | input | 1 | Allows start-bit detection |
| two_stop | input | 1 | 1 selects two stop bits |
| bit_div | input | 16 | Clock cycles per 1/16 bit (0 behaves as 1) |
| idle_bits | input | 8 | Idle bit times that end a message (at least 1) |
| afull_level | input | 8 | Almost-full threshold |
| fifo_count | input | 8 | Current FIFO word count |
| fifo_full | input | 1 | FIFO cannot accept a word |
| clr_flags | input | 3 | Write-one-to-clear: done, overflow, framing |
| fifo_wr_en | output | 1 | One-cycle FIFO write strobe |
| fifo_wr_data | output | 8 | Received character |
| msg_count | output | 16 | Character count of last completed message |
| rx_done | output | 1 | Sticky: a message has completed |
| rx_almost_full | output | 1 | FIFO count at or above threshold |
| rx_overflow | output | 1 | Sticky: character lost to a full FIFO |
| rx_frame_err | output | 1 | Sticky: stop bit sampled low |

## Verification
The assertions assume that `bit_div`, `idle_bits` and `two_stop` stay constant while a character or gap is in progress, and that `idle_bits` is at least one, so an end of message can never coincide with a completing character. The write-guard property relates each write to the `fifo_full` value of the previous cycle, so it assumes `fifo_full` only changes while the line is idle. The stimulus changes every configuration and `fifo_full` only between characters, with the line held high. It always leaves a gap of several bit times before it reads back the count.

// File: rtl/uart_msg_rx_pkg.sv
package uart_msg_rx_pkg;

    typedef enum logic [2:0] {
        RX_HUNT,
        RX_START,
        RX_DATA,
        RX_STOP1,
        RX_STOP2,
        RX_WAITHI
    } rx_state_e;

    localparam int unsigned OVERSAMPLE = 16;
    localparam int unsigned CHAR_BITS  = 8;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] bit_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = ({1'b0, cnt_q} + 1'b1) >= {1'b0, bit_div};
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
    import uart_msg_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       line,
    input  logic       enable,
    input  logic       two_stop,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       frame_err,
    output logic       busy
);
    typedef struct packed {
        rx_state_e   state;
        logic [3:0]  os;
        logic [2:0]  nbit;
        logic [7:0]  shift;
        logic        valid;
        logic        ferr;
    } frm_t;

    frm_t d, q;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.ferr  = 1'b0;
        unique case (q.state)
            RX_HUNT: begin
                if (tick && enable && !line) begin
                    d.state = RX_START;
                    d.os    = 4'd1;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (q.os == 4'd8) begin
                        if (!line) begin
                            d.state = RX_DATA;
                            d.os    = '0;
                            d.nbit  = '0;
                        end else begin
                            d.state = RX_HUNT;
                        end
                    end else begin
                        d.os = q.os + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (tick) begin
                    if (q.os == 4'd15) begin
                        d.shift = {line, q.shift[7:1]};
                        d.os    = '0;
                        d.nbit  = q.nbit + 1'b1;
                        if (q.nbit == 3'd7) d.state = RX_STOP1;
                    end else begin
                        d.os = q.os + 1'b1;
                    end
                end
            end
            RX_STOP1, RX_STOP2: begin
                if (tick) begin
                    if (q.os == 4'd15) begin
                        d.os = '0;
                        if (!line) begin
                            d.ferr  = 1'b1;
                            d.state = RX_WAITHI;
                        end else if (q.state == RX_STOP1 && two_stop) begin
                            d.state = RX_STOP2;
                        end else begin
                            d.valid = 1'b1;
                            d.state = RX_HUNT;
                        end
                    end else begin
                        d.os = q.os + 1'b1;
                    end
                end
            end
            RX_WAITHI: begin
                if (line) d.state = RX_HUNT;
            end
            default: d.state = RX_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= RX_HUNT;
        end else begin
            q <= d;
        end
    end

    assign byte_valid = q.valid;
    assign byte_data  = q.shift;
    assign frame_err  = q.ferr;
    assign busy       = (q.state != RX_HUNT);

    // R10: with the receiver disabled, an idle hunt stays idle
    a_r10_disabled_stays_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == RX_HUNT && !enable) |=> (q.state == RX_HUNT));

    // R1: a completed character is reported for a single cycle
    a_r1_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |=> !q.valid);

    // R3: a character completes only out of a stop-bit state
    a_r3_valid_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.valid) |-> ($past(q.state) == RX_STOP1 || $past(q.state) == RX_STOP2));
endmodule

// File: rtl/uart_msg_rx.sv
module uart_msg_rx #(
    parameter int unsigned DIV_W = 16,
    parameter int unsigned LVL_W = 8,
    parameter int unsigned GAP_W = 8,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_line,
    input  logic             rx_enable,
    input  logic             two_stop,
    input  logic [DIV_W-1:0] bit_div,
    input  logic [GAP_W-1:0] idle_bits,
    input  logic [LVL_W-1:0] afull_level,
    input  logic [LVL_W-1:0] fifo_count,
    input  logic             fifo_full,
    input  logic [2:0]       clr_flags,
    output logic             fifo_wr_en,
    output logic [7:0]       fifo_wr_data,
    output logic [CNT_W-1:0] msg_count,
    output logic             rx_done,
    output logic             rx_almost_full,
    output logic             rx_overflow,
    output logic             rx_frame_err
);
    localparam int unsigned SUB_W = $clog2(uart_msg_rx_pkg::OVERSAMPLE);

    logic       line_s, tick, byte_valid, frame_err, busy, end_msg;
    logic [7:0] byte_data;

    uart_rx_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(rx_line), .sync_out(line_s)
    );

    uart_rx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .bit_div(bit_div), .tick(tick)
    );

    uart_rx_framer u_framer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line(line_s),
        .enable(rx_enable), .two_stop(two_stop),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .frame_err(frame_err), .busy(busy)
    );

    typedef struct packed {
        logic [CNT_W-1:0] byte_cnt;
        logic [CNT_W-1:0] msg_cnt;
        logic [SUB_W-1:0] sub;
        logic [GAP_W-1:0] gap;
        logic             done;
        logic             ovf;
        logic             ferr;
        logic             wr_en;
        logic [7:0]       wr_data;
    } msg_t;

    msg_t d, q;

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        end_msg = 1'b0;

        // write-one-to-clear; a set later in this process wins
        if (clr_flags[0]) d.done = 1'b0;
        if (clr_flags[1]) d.ovf  = 1'b0;
        if (clr_flags[2]) d.ferr = 1'b0;

        // idle gap measured in whole bit times
        if (busy) begin
            d.sub = '0;
            d.gap = '0;
        end else if (tick) begin
            d.sub = q.sub + 1'b1;
            if (q.sub == '1 && q.gap != '1) d.gap = q.gap + 1'b1;
        end

        if (byte_valid) begin
            if (fifo_full) begin
                d.ovf = 1'b1;
            end else begin
                d.wr_en   = 1'b1;
                d.wr_data = byte_data;
                if (q.byte_cnt != '1) d.byte_cnt = q.byte_cnt + 1'b1;
            end
        end

        if (frame_err) d.ferr = 1'b1;

        if (!busy && !byte_valid && q.byte_cnt != '0 && q.gap >= idle_bits) begin
            end_msg    = 1'b1;
            d.msg_cnt  = q.byte_cnt;
            d.byte_cnt = '0;
            d.done     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fifo_wr_en     = q.wr_en;
    assign fifo_wr_data   = q.wr_data;
    assign msg_count      = q.msg_cnt;
    assign rx_done        = q.done;
    assign rx_overflow    = q.ovf;
    assign rx_frame_err   = q.ferr;
    assign rx_almost_full = (fifo_count >= afull_level);

    // R5: a write is never issued for a character that met a full FIFO
    a_r5_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_en |-> !$past(fifo_full));

    // R6: overflow stays latched until cleared
    a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overflow && !clr_flags[1]) |=> rx_overflow);

    // R7: done stays latched until cleared
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !clr_flags[0]) |=> rx_done);

    // R8: the reported count moves only at an end of message
    a_r8_count_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !end_msg |=> $stable(msg_count));

    // R7: the running count restarts after an end of message
    a_r7_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
        end_msg |=> (q.byte_cnt == '0));
endmodule

// File: tb/uart_msg_rx_test.sv
`timescale 1ns/1ps
module uart_msg_rx_test;
    localparam int DIV = 2;
    localparam int BIT = 16 * DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_line = 1'b1;
    logic        rx_enable = 1'b1;
    logic        two_stop = 1'b0;
    logic [15:0] bit_div = 16'(DIV);
    logic [7:0]  idle_bits = 8'd4;
    logic [7:0]  afull_level = 8'd0;
    logic [7:0]  fifo_count = 8'd0;
    logic        fifo_full = 1'b0;
    logic [2:0]  clr_flags = 3'b000;
    logic        fifo_wr_en;
    logic [7:0]  fifo_wr_data;
    logic [15:0] msg_count;
    logic        rx_done, rx_almost_full, rx_overflow, rx_frame_err;

    int total = 0;
    int bad = 0;
    logic [7:0] expq[$];

    always #2.5 clk = ~clk;

    uart_msg_rx uut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .rx_enable(rx_enable),
        .two_stop(two_stop), .bit_div(bit_div), .idle_bits(idle_bits),
        .afull_level(afull_level), .fifo_count(fifo_count), .fifo_full(fifo_full),
        .clr_flags(clr_flags), .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
        .msg_count(msg_count), .rx_done(rx_done), .rx_almost_full(rx_almost_full),
        .rx_overflow(rx_overflow), .rx_frame_err(rx_frame_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard at every write (R1)
    always @(negedge clk) begin
        if (rst_n && fifo_wr_en) begin
            if (expq.size() == 0) begin
                check(1'b0, "R1 unexpected write", int'(fifo_wr_data), -1);
            end else begin
                logic [7:0] e;
                e = expq.pop_front();
                check(fifo_wr_data == e, "R1 written character", int'(fifo_wr_data), int'(e));
            end
        end
    end

    task automatic drive_bit(input logic v);
        rx_line = v;
        repeat (BIT) @(posedge clk);
        #1;
    endtask

    // bad_stop: 0 none, 1 first stop low, 2 second stop low
    task automatic send_char(input logic [7:0] b, input int nstop, input int bad_stop, input bit expect_wr);
        if (expect_wr) expq.push_back(b);
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(b[i]);
        for (int s = 1; s <= nstop; s++) drive_bit(bad_stop == s ? 1'b0 : 1'b1);
        rx_line = 1'b1;
    endtask

    task automatic idle(input int nbits);
        rx_line = 1'b1;
        repeat (nbits * BIT) @(posedge clk);
        #1;
    endtask

    task automatic pulse_clear(input logic [2:0] v);
        clr_flags = v;
        @(posedge clk);
        #1;
        clr_flags = 3'b000;
        @(posedge clk);
        #1;
    endtask

    task automatic queue_drained(input string req);
        check(expq.size() == 0, req, expq.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        // reset state
        check(msg_count == 16'd0, "R8 reset count", int'(msg_count), 0);
        check(!rx_done && !rx_overflow && !rx_frame_err, "R6 reset flags",
              int'({rx_done, rx_overflow, rx_frame_err}), 0);
        check(!fifo_wr_en, "R1 reset write strobe", int'(fifo_wr_en), 0);

        // R9 almost full threshold
        afull_level = 8'd6; fifo_count = 8'd5; #1;
        check(!rx_almost_full, "R9 below level", int'(rx_almost_full), 0);
        fifo_count = 8'd6; #1;
        check(rx_almost_full, "R9 equal level", int'(rx_almost_full), 1);
        fifo_count = 8'd7; #1;
        check(rx_almost_full, "R9 above level", int'(rx_almost_full), 1);
        afull_level = 8'd0; fifo_count = 8'd0; #1;
        check(rx_almost_full, "R9 zero level", int'(rx_almost_full), 1);
        afull_level = 8'd200; #1;

        // R1/R7: three-character message, one stop bit
        send_char(8'hA5, 1, 0, 1'b1);
        send_char(8'h3C, 1, 0, 1'b1);
        send_char(8'hFF, 1, 0, 1'b1);
        check(msg_count == 16'd0, "R8 count held mid-gap", int'(msg_count), 0);
        idle(6);
        check(msg_count == 16'd3, "R7 message count", int'(msg_count), 3);
        check(rx_done, "R7 done set", int'(rx_done), 1);
        queue_drained("R1 all characters written");

        pulse_clear(3'b001);
        check(!rx_done, "R6 done cleared", int'(rx_done), 0);

        // R8 empty gap changes nothing
        idle(8);
        check(msg_count == 16'd3, "R8 empty gap count", int'(msg_count), 3);
        check(!rx_done, "R8 empty gap done", int'(rx_done), 0);

        // R2 short low glitch rejected
        rx_line = 1'b0;
        repeat (4) @(posedge clk);
        #1 rx_line = 1'b1;
        idle(2);
        send_char(8'h81, 1, 0, 1'b1);
        idle(6);
        check(msg_count == 16'd1, "R2 glitch not counted", int'(msg_count), 1);
        queue_drained("R2 glitch no write");

        // R3 two stop bits; R4 second stop low
        two_stop = 1'b1;
        send_char(8'h5A, 2, 0, 1'b1);
        send_char(8'h66, 2, 2, 1'b0);
        idle(6);
        check(rx_frame_err, "R4 frame error on second stop", int'(rx_frame_err), 1);
        check(msg_count == 16'd1, "R3 count with two stops", int'(msg_count), 1);
        queue_drained("R3 two-stop character written");
        pulse_clear(3'b100);
        check(!rx_frame_err, "R6 frame error cleared", int'(rx_frame_err), 0);

        // R4 single stop low
        two_stop = 1'b0;
        send_char(8'h99, 1, 1, 1'b0);
        idle(2);
        send_char(8'h42, 1, 0, 1'b1);
        idle(6);
        check(rx_frame_err, "R4 frame error on stop", int'(rx_frame_err), 1);
        check(msg_count == 16'd1, "R4 bad character not counted", int'(msg_count), 1);
        queue_drained("R4 bad character discarded");
        pulse_clear(3'b100);

        // R5 overflow
        fifo_full = 1'b1;
        send_char(8'h11, 1, 0, 1'b0);
        idle(1);
        fifo_full = 1'b0;
        send_char(8'h22, 1, 0, 1'b1);
        send_char(8'h23, 1, 0, 1'b1);
        idle(6);
        check(rx_overflow, "R5 overflow set", int'(rx_overflow), 1);
        check(msg_count == 16'd2, "R5 lost character not counted", int'(msg_count), 2);
        queue_drained("R5 no write while full");
        pulse_clear(3'b010);
        check(!rx_overflow, "R6 overflow cleared", int'(rx_overflow), 0);

        // R10 disabled receiver
        pulse_clear(3'b001);
        rx_enable = 1'b0;
        send_char(8'h33, 1, 0, 1'b0);
        idle(6);
        check(msg_count == 16'd2, "R10 disabled count", int'(msg_count), 2);
        check(!rx_done, "R10 disabled no done", int'(rx_done), 0);
        queue_drained("R10 disabled no write");
        rx_enable = 1'b1;
        idle(1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule